// File: doc/BRIEF.md
# HDLC Receive Frame Filter and Reporter

This block sits after a serial HDLC receiver that has already recovered bytes and told flags apart from data. Each input word carries a flag marker, a channel number and a byte. The block tracks frame boundaries, keeps only frames whose first byte equals the configured station address, runs the 16-bit frame check over each accepted frame, and turns the result into a stream of 16-bit report words for a host: one start word, one word per further byte, and one end word that says whether the check passed.

Input and output both use a valid/ready handshake. The output is a single register. When the host stalls, the input side is held off, so no word is dropped. Each accepted input word yields at most one report word.

Top module: `hdlc_rx_reporter`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An input word is a flag when bits [15:12] are 4'b1111. Bits [11:8] are the channel and bits [7:0] the byte. Data words that arrive before the first flag since reset produce no output.
- R3: A flag that closes no open, accepted frame produces no output. This covers idle flags in a row, and the flag that ends a discarded frame.
- R4: The first data byte after a flag is the address. If it equals `dev_addr`, the block emits the start word {4'b1111, channel, 8'hFF} and begins the frame check, with the address included.
- R5: If the address byte differs from `dev_addr`, that byte and every data byte up to the next flag produce no output.
- R6: Every further data byte of an accepted frame is emitted as {4'b0000, channel, byte}.
- R7: A flag that follows an accepted frame emits the end word {4'b1111, channel, v, 7'b0}. The check is CRC-16 with polynomial 0x1021, preset 0xFFFF, shifted LSB first over every byte from the address through both check bytes. v is 1 when the remainder equals 0xF0B8 and at least 4 bytes lay between the flags.
- R8: An accepted frame whose remainder differs from 0xF0B8 ends with v = 0.
- R9: An accepted frame with fewer than 4 bytes between its flags ends with v = 0, even when its remainder is 0xF0B8.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_word` holds its value and `in_ready` is 0. When `out_ready` is 1, a new word can be accepted in the same cycle the held word is taken, and no report word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word |
| in_word | input | 16 | Tagged flag or data word |
| dev_addr | input | 8 | Station address to match |
| out_valid | output | 1 | Report word present |
| out_ready | input | 1 | Host takes the report word |
| out_word | output | 16 | Start, data or end report |

## Verification
Two things can fall in the same clock edge: the host draining the held report word, and the block accepting the next input word and loading a new report. The bench provokes this by stalling the host after a start word, holding a data word on the input, and then raising `out_ready` alone. It judges the result by checking that the start word stayed put during the stall, that the data word appears right after the release, and that the frame still closes with the correct end word. Every other word is exchanged with the host always ready, so the edge at which each report appears is known.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
   localparam logic [3:0] FLAG_TAG = 4'b1111;
   localparam logic [3:0] DATA_TAG = 4'b0000;

   typedef enum logic [1:0] {
      ST_HUNT   = 2'd0,
      ST_GAP    = 2'd1,
      ST_OPEN   = 2'd2,
      ST_REJECT = 2'd3
   } frm_state_t;

   typedef struct packed {
      logic       is_flag;
      logic [3:0] chan;
      logic [7:0] octet;
   } rx_item_t;
endpackage

// File: rtl/hrf_decode.sv
module hrf_decode
   import hdlc_rx_pkg::*;
(
   input  logic [15:0] word_i,
   output rx_item_t    item_o
);
   always_comb begin
      item_o.is_flag = (word_i[15:12] == FLAG_TAG);
      item_o.chan    = word_i[11:8];
      item_o.octet   = word_i[7:0];
   end
endmodule

// File: rtl/hrf_crc.sv
module hrf_crc #(
   parameter int          CRC_W     = 16,
   parameter logic [15:0] POLY      = 16'h1021,
   parameter logic [15:0] PRESET    = 16'hFFFF,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             restart_i,
   input  logic [7:0]       octet_i,
   output logic [CRC_W-1:0] crc_o
);
   localparam logic [CRC_W-1:0] POLY_REV = {<<{POLY[CRC_W-1:0]}};

   logic [CRC_W-1:0] base;
   logic [CRC_W-1:0] nxt;

   assign base = restart_i ? PRESET[CRC_W-1:0] : crc_o;

   generate
      if (CRC_W != 16) begin : g_bad_width
         $error("hrf_crc: CRC_W must be 16");
      end
      if (LSB_FIRST) begin : g_lsb
         always_comb begin
            nxt = base;
            for (int i = 0; i < 8; i++) begin
               if (nxt[0] ^ octet_i[i]) nxt = (nxt >> 1) ^ POLY_REV;
               else                     nxt = nxt >> 1;
            end
         end
      end else begin : g_msb
         always_comb begin
            nxt = base;
            for (int i = 7; i >= 0; i--) begin
               if (nxt[CRC_W-1] ^ octet_i[i]) nxt = (nxt << 1) ^ POLY[CRC_W-1:0];
               else                           nxt = nxt << 1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    crc_o <= PRESET[CRC_W-1:0];
      else if (en_i) crc_o <= nxt;
   end
endmodule

// File: rtl/hdlc_rx_reporter.sv
module hdlc_rx_reporter
   import hdlc_rx_pkg::*;
#(
   parameter int          WORD_W    = 16,
   parameter int          ADDR_W    = 8,
   parameter int          MIN_BYTES = 4,
   parameter bit          LSB_FIRST = 1'b1,
   parameter logic [15:0] POLY      = 16'h1021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word
);
   localparam int          CNT_W    = $clog2(MIN_BYTES + 1);
   localparam logic [15:0] RESIDUE  = LSB_FIRST ? 16'hF0B8 : 16'h1D0F;
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_BYTES);

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("hdlc_rx_reporter: WORD_W must be 16");
      end
      if (ADDR_W != 8) begin : g_bad_addr
         $error("hdlc_rx_reporter: ADDR_W must be 8");
      end
      if (MIN_BYTES < 1) begin : g_bad_min
         $error("hdlc_rx_reporter: MIN_BYTES must be at least 1");
      end
   endgenerate

   rx_item_t   item;
   frm_state_t st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [15:0] crc_q;
   logic        take, emit, crc_en, crc_restart, frame_good;
   logic [WORD_W-1:0] emit_word;

   hrf_decode u_dec (
      .word_i (in_word),
      .item_o (item)
   );

   hrf_crc #(
      .CRC_W     (16),
      .POLY      (POLY),
      .PRESET    (16'hFFFF),
      .LSB_FIRST (LSB_FIRST)
   ) u_crc (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (crc_en),
      .restart_i (crc_restart),
      .octet_i   (item.octet),
      .crc_o     (crc_q)
   );

   assign in_ready   = !out_valid || out_ready;
   assign take       = in_valid && in_ready;
   assign frame_good = (crc_q == RESIDUE) && (cnt_q >= CNT_TOP);

   always_comb begin
      st_d        = st_q;
      cnt_d       = cnt_q;
      emit        = 1'b0;
      emit_word   = '0;
      crc_en      = 1'b0;
      crc_restart = 1'b0;
      if (take) begin
         if (item.is_flag) begin
            if (st_q == ST_OPEN) begin
               emit      = 1'b1;
               emit_word = {FLAG_TAG, item.chan, frame_good, 7'b0};
            end
            st_d = ST_GAP;
         end else begin
            unique case (st_q)
               ST_GAP: begin
                  if (item.octet == dev_addr) begin
                     emit        = 1'b1;
                     emit_word   = {FLAG_TAG, item.chan, 8'hFF};
                     crc_en      = 1'b1;
                     crc_restart = 1'b1;
                     cnt_d       = CNT_W'(1);
                     st_d        = ST_OPEN;
                  end else begin
                     st_d = ST_REJECT;
                  end
               end
               ST_OPEN: begin
                  emit      = 1'b1;
                  emit_word = {DATA_TAG, item.chan, item.octet};
                  crc_en    = 1'b1;
                  if (cnt_q != CNT_TOP) cnt_d = cnt_q + CNT_W'(1);
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_HUNT;
         cnt_q     <= '0;
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         if (take && emit) begin
            out_valid <= 1'b1;
            out_word  <= emit_word;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

   // R10
   stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R3
   quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && item.is_flag && st_q != ST_OPEN) |=> !out_valid);

   // R5
   reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && st_q == ST_REJECT) |=> !out_valid);

   // R4
   start_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !item.is_flag && st_q == ST_GAP && item.octet == dev_addr)
      |=> (out_valid && out_word[15:12] == FLAG_TAG && out_word[7:0] == 8'hFF));

   // R7
   end_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_word[15:12] == FLAG_TAG && out_word[7:0] != 8'hFF)
      |-> (out_word[6:0] == 7'b0));
endmodule

// File: tb/hdlc_rx_reporter_tb_top.sv
module hdlc_rx_reporter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_word = '0;
   logic [7:0]  dev_addr = 8'h5A;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_word;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   hdlc_rx_reporter dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .dev_addr(dev_addr), .out_valid(out_valid),
      .out_ready(out_ready), .out_word(out_word)
   );

   // {expect_valid, expect_word, input_word}
   localparam int NV = 13;
   localparam logic [32:0] VEC [NV] = '{
      {1'b0, 16'h0000, 16'h0311},   // R2 data before first flag
      {1'b0, 16'h0000, 16'hF37E},   // R3 opening flag
      {1'b0, 16'h0000, 16'hF37E},   // R3 idle flag
      {1'b1, 16'hF3FF, 16'h035A},   // R4 address match
      {1'b1, 16'h0342, 16'h0342},   // R6 data
      {1'b1, 16'hF300, 16'hF37E},   // R9 short frame
      {1'b0, 16'h0000, 16'h0377},   // R5 address mismatch
      {1'b0, 16'h0000, 16'h0388},   // R5 discarded byte
      {1'b0, 16'h0000, 16'hF37E},   // R3 flag after discarded frame
      {1'b1, 16'hF9FF, 16'h095A},   // R4 other channel
      {1'b1, 16'h0901, 16'h0901},   // R6 data other channel
      {1'b1, 16'hF900, 16'hF97E},   // R9 short frame other channel
      {1'b0, 16'h0000, 16'hF97E}    // R3 idle flag
   };

   task automatic check(input bit ok, input string req, input logic [16:0] act, input logic [16:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_expect(input logic [15:0] w, input bit ev, input logic [15:0] ew, input string req);
      send(w);
      if (ev) check(out_valid && out_word == ew, req, {out_valid, out_word}, {1'b1, ew});
      else    check(!out_valid, req, {out_valid, out_word}, 17'h0);
   endtask

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
         else             r = r >> 1;
      end
      return r;
   endfunction

   // sends a frame on channel ch; corrupt flips one payload bit after the FCS is computed
   task automatic send_frame(input logic [3:0] ch, input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input logic [7:0] b3, input int n,
                             input bit corrupt, input bit ev_good, input string req);
      logic [7:0] bytes [4];
      logic [15:0] c = 16'hFFFF;
      logic [15:0] fcs;
      bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3;
      for (int i = 0; i < n; i++) c = crc_step(c, bytes[i]);
      fcs = ~c;
      if (corrupt && n > 1) bytes[1] = bytes[1] ^ 8'h10;
      send_expect({4'hF, ch, 8'h7E}, 1'b0, 16'h0, "R3");
      send_expect({4'h0, ch, bytes[0]}, 1'b1, {4'hF, ch, 8'hFF}, "R4");
      for (int i = 1; i < n; i++)
         send_expect({4'h0, ch, bytes[i]}, 1'b1, {4'h0, ch, bytes[i]}, "R6");
      send_expect({4'h0, ch, fcs[7:0]},  1'b1, {4'h0, ch, fcs[7:0]},  "R6");
      send_expect({4'h0, ch, fcs[15:8]}, 1'b1, {4'h0, ch, fcs[15:8]}, "R6");
      send_expect({4'hF, ch, 8'h7E}, 1'b1, {4'hF, ch, ev_good, 7'b0}, req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!out_valid && in_ready, "R1", {out_valid, 15'h0, in_ready}, 17'h1);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && in_ready, "R1", {out_valid, 15'h0, in_ready}, 17'h1);

      for (int k = 0; k < NV; k++)
         send_expect(VEC[k][15:0], VEC[k][32], VEC[k][31:16], "R2-table");

      // R7 good frame, 4 bytes plus FCS
      send_frame(4'h5, 8'h5A, 8'h03, 8'h11, 8'h22, 4, 1'b0, 1'b1, "R7");
      // R8 corrupted payload
      send_frame(4'h5, 8'h5A, 8'h03, 8'h11, 8'h22, 4, 1'b1, 1'b0, "R8");
      // R9 address plus FCS only: remainder correct but 3 bytes
      send_frame(4'h6, 8'h5A, 8'h00, 8'h00, 8'h00, 1, 1'b0, 1'b0, "R9");
      // R7 minimum length good frame: address, one byte, FCS
      send_frame(4'h2, 8'h5A, 8'hC3, 8'h00, 8'h00, 2, 1'b0, 1'b1, "R7");

      // R10 stall and same-cycle drain/refill
      send_expect(16'hF57E, 1'b0, 16'h0, "R3");
      out_ready = 1'b0;
      send(16'h055A);
      check(out_valid && out_word == 16'hF5FF && !in_ready, "R10",
            {out_valid, out_word}, {1'b1, 16'hF5FF});
      in_valid = 1'b1;
      in_word  = 16'h0533;
      @(negedge clk);
      @(negedge clk);
      check(out_valid && out_word == 16'hF5FF && !in_ready, "R10",
            {out_valid, out_word}, {1'b1, 16'hF5FF});
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid && out_word == 16'h0533, "R10",
            {out_valid, out_word}, {1'b1, 16'h0533});
      send_expect(16'hF57E, 1'b1, 16'hF500, "R10");
      @(negedge clk);
      check(!out_valid && in_ready, "R10", {out_valid, 15'h0, in_ready}, 17'h1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule